// File: doc/BRIEF.md
# Saturating Transmit Event Tally Register

This block keeps four small statistics counters for a transmit path and presents them together as one 16-bit word that a processor reads. The transmit engine pulses a completion strobe once for each packet it finishes. With that strobe it supplies four things about the packet: how many collisions it met, whether it deferred, whether it hit excessive deferral, and whether it was sent successfully. From these the block decides which of the four counters advance for that packet. A counter advances at most once per packet, however many events of its kind the packet met.

The counters never wrap. Once a counter reaches 15 it holds there, and it asserts an interrupt request that stays high until software reads the word. A read returns the current value and clears all four counters in the same cycle. A transmit service routine can therefore keep exact totals by reading the word now and then, without any per-packet interrupt. If a packet completes in the same cycle as a read, the read still returns the old totals and the new event is not lost: it becomes the first count of the next period.

Top module: `tx_event_tally`

## Requirements
- R1: The word is made of four 4-bit fields. Single-collision count is bits [3:0], deferred count is bits [7:4], multiple-collision count is bits [11:8] and excessive-deferral count is bits [15:12]. All fields are 0 after reset.
- R2: A field that has reached 15 holds at 15 when more of its events arrive, and it never wraps to 0.
- R3: The interrupt output is high in every cycle in which at least one field equals 15. It stays high with no further events until a read clears the counters.
- R4: A read strobe returns the current word in that same cycle. From the next cycle on, all four fields read 0 (apart from R10).
- R5: A field changes only on a clock edge where the completion strobe or the read strobe is high. Between two reads it advances by at most 1 per completion strobe.
- R6: The single-collision field advances for a completed packet only when the success flag is 1 and the collision count equals exactly 1. A failed packet with one collision does not count.
- R7: The multiple-collision field advances for a completed packet whose collision count is between 2 and 16 inclusive, whatever its success flag. Counts of 0, 1, or 17 and above do not advance it.
- R8: The deferred field advances by exactly 1 for a completed packet whose deferred flag is 1.
- R9: The excessive-deferral field advances by exactly 1 for a completed packet whose excessive-deferral flag is 1.
- R10: When a read and a completion occur in the same cycle, the read returns the old word. Each field that the completing packet hits then shows 1, and every other field shows 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_done | input | 1 | One-cycle strobe per finished transmit packet |
| pkt_coll | input | 5 | Number of collisions the packet met (0 to 31) |
| pkt_deferred | input | 1 | Packet deferred at least once |
| pkt_exc_defer | input | 1 | Packet hit excessive deferral |
| pkt_ok | input | 1 | Packet was sent successfully |
| rd_strobe | input | 1 | Processor read of the word; clears the counters |
| stat_word | output | 16 | Packed counter fields, layout as in R1 |
| irq | output | 1 | High while any field equals 15 |

## Verification
The bench pushes one counter to 15 and then keeps feeding it events. A design that wraps would show 0 and drop the interrupt, and one that counts past the limit would corrupt the neighbouring field. The bench probes the collision count at its edges: one collision with success and with failure, 16 collisions, and 17 collisions. These expose an off-by-one range test or a missing success qualifier. It also issues a read in the same cycle as a completion. A design that lets the clear win would lose the event, and one that lets the increment win would return 0 or keep the old total.

// File: rtl/tx_event_tally.sv
module tx_event_tally #(
  parameter int CNT_W    = 4,
  parameter int COLL_W   = 5,
  parameter int MULTI_LO = 2,
  parameter int MULTI_HI = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pkt_done,
  input  logic [COLL_W-1:0]   pkt_coll,
  input  logic                pkt_deferred,
  input  logic                pkt_exc_defer,
  input  logic                pkt_ok,
  input  logic                rd_strobe,
  output logic [4*CNT_W-1:0]  stat_word,
  output logic                irq
);

  localparam int NUM = 4;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [COLL_W-1:0] C_ONE = COLL_W'(1);
  localparam logic [COLL_W-1:0] C_LO  = COLL_W'(MULTI_LO);
  localparam logic [COLL_W-1:0] C_HI  = COLL_W'(MULTI_HI);

  logic [NUM-1:0] hit;
  logic [NUM-1:0] full;

  assign hit[0] = pkt_done & pkt_ok & (pkt_coll == C_ONE);
  assign hit[1] = pkt_done & pkt_deferred;
  assign hit[2] = pkt_done & (pkt_coll >= C_LO) & (pkt_coll <= C_HI);
  assign hit[3] = pkt_done & pkt_exc_defer;

  for (genvar g = 0; g < NUM; g++) begin : g_cnt
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cnt <= '0;
      else if (rd_strobe)
        cnt <= hit[g] ? CNT_W'(1) : '0;
      else if (hit[g] && cnt != CNT_MAX)
        cnt <= cnt + 1'b1;
    end

    assign stat_word[g*CNT_W +: CNT_W] = cnt;
    assign full[g] = (cnt == CNT_MAX);
  end

  assign irq = |full;

endmodule

// File: rtl/tx_event_tally_chk.sv
module tx_event_tally_chk #(
  parameter int CNT_W  = 4,
  parameter int COLL_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pkt_done,
  input logic [COLL_W-1:0]  pkt_coll,
  input logic               pkt_deferred,
  input logic               pkt_exc_defer,
  input logic               pkt_ok,
  input logic               rd_strobe,
  input logic [4*CNT_W-1:0] stat_word,
  input logic               irq
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_done && !rd_strobe |=> $stable(stat_word));  // R5

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && !pkt_done |=> stat_word == '0);  // R4

  AST_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !irq);  // R3

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !rd_strobe |=> irq);  // R3

  AST_READ_HIT_DEFER: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe && pkt_done && pkt_deferred |=> stat_word[2*CNT_W-1:CNT_W] == CNT_W'(1));  // R10

  AST_FAILED_NO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done && !pkt_ok && !rd_strobe |=> $stable(stat_word[CNT_W-1:0]));  // R6

  for (genvar g = 0; g < 4; g++) begin : g_fld
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      stat_word[g*CNT_W +: CNT_W] == CNT_MAX && !rd_strobe |=> stat_word[g*CNT_W +: CNT_W] == CNT_MAX);  // R2

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_strobe |=> (stat_word[g*CNT_W +: CNT_W] == $past(stat_word[g*CNT_W +: CNT_W])) ||
                     (stat_word[g*CNT_W +: CNT_W] == CNT_W'($past(stat_word[g*CNT_W +: CNT_W]) + 1'b1)));  // R5
  end

endmodule

bind tx_event_tally tx_event_tally_chk #(.CNT_W(CNT_W), .COLL_W(COLL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .pkt_coll(pkt_coll),
  .pkt_deferred(pkt_deferred), .pkt_exc_defer(pkt_exc_defer), .pkt_ok(pkt_ok),
  .rd_strobe(rd_strobe), .stat_word(stat_word), .irq(irq)
);

// File: tb/tx_event_tally_test.sv
`timescale 1ns/1ps
module tx_event_tally_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pkt_done = 1'b0;
  logic [4:0]  pkt_coll = '0;
  logic        pkt_deferred = 1'b0;
  logic        pkt_exc_defer = 1'b0;
  logic        pkt_ok = 1'b0;
  logic        rd_strobe = 1'b0;
  logic [15:0] stat_word;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tx_event_tally uut (
    .clk(clk), .rst_n(rst_n), .pkt_done(pkt_done), .pkt_coll(pkt_coll),
    .pkt_deferred(pkt_deferred), .pkt_exc_defer(pkt_exc_defer), .pkt_ok(pkt_ok),
    .rd_strobe(rd_strobe), .stat_word(stat_word), .irq(irq)
  );

  // {coll[4:0], deferred, exc_defer, ok, expected word after packet}
  localparam logic [23:0] VEC [9] = '{
    {5'd1,  1'b0, 1'b0, 1'b1, 16'h0001},  // R6 one collision, success
    {5'd1,  1'b0, 1'b0, 1'b0, 16'h0001},  // R6 one collision, failed
    {5'd2,  1'b0, 1'b0, 1'b1, 16'h0101},  // R7 low edge
    {5'd16, 1'b0, 1'b0, 1'b0, 16'h0201},  // R7 high edge
    {5'd17, 1'b0, 1'b0, 1'b0, 16'h0201},  // R7 above range
    {5'd0,  1'b1, 1'b0, 1'b1, 16'h0211},  // R8
    {5'd0,  1'b1, 1'b1, 1'b0, 16'h1221},  // R9 with R8
    {5'd0,  1'b0, 1'b0, 1'b1, 16'h1221},  // R1 clean packet
    {5'd3,  1'b1, 1'b0, 1'b1, 16'h1331}   // R7 R8 together
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [4:0] c, input logic d, input logic x, input logic ok);
    @(negedge clk);
    pkt_done = 1'b1; pkt_coll = c; pkt_deferred = d; pkt_exc_defer = x; pkt_ok = ok;
    @(negedge clk);
    pkt_done = 1'b0; pkt_coll = '0; pkt_deferred = 1'b0; pkt_exc_defer = 1'b0; pkt_ok = 1'b0;
  endtask

  task automatic do_read(input string req, input logic [15:0] exp_old);
    @(negedge clk);
    rd_strobe = 1'b1;
    #1 check(req, stat_word, exp_old);
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", stat_word, 16'h0000);
    check("R3 reset irq", {15'd0, irq}, 16'h0000);
    rst_n = 1'b1;

    for (int i = 0; i < 9; i++) begin
      send(VEC[i][23:19], VEC[i][18], VEC[i][17], VEC[i][16]);
      check($sformatf("R1 R6 R7 R8 R9 vector %0d", i), stat_word, VEC[i][15:0]);
    end

    repeat (4) @(negedge clk);
    check("R5 idle no change", stat_word, 16'h1331);

    do_read("R4 read returns word", 16'h1331);
    check("R4 cleared after read", stat_word, 16'h0000);

    for (int i = 0; i < 15; i++) send(5'd0, 1'b1, 1'b0, 1'b1);
    check("R2 reaches 15", stat_word, 16'h00F0);
    check("R3 irq at 15", {15'd0, irq}, 16'h0001);
    for (int i = 0; i < 3; i++) send(5'd0, 1'b1, 1'b0, 1'b1);
    check("R2 holds at 15", stat_word, 16'h00F0);
    repeat (5) @(negedge clk);
    check("R3 irq held", {15'd0, irq}, 16'h0001);
    do_read("R4 read saturated", 16'h00F0);
    check("R4 clear after saturate", stat_word, 16'h0000);
    check("R3 irq dropped", {15'd0, irq}, 16'h0000);

    send(5'd1, 1'b0, 1'b0, 1'b1);
    send(5'd1, 1'b0, 1'b0, 1'b1);
    check("R6 two singles", stat_word, 16'h0002);
    @(negedge clk);
    rd_strobe = 1'b1;
    pkt_done = 1'b1; pkt_coll = 5'd1; pkt_deferred = 1'b1; pkt_ok = 1'b1;
    #1 check("R10 read returns old", stat_word, 16'h0002);
    @(negedge clk);
    rd_strobe = 1'b0;
    pkt_done = 1'b0; pkt_coll = '0; pkt_deferred = 1'b0; pkt_ok = 1'b0;
    check("R10 new event kept", stat_word, 16'h0011);

    for (int i = 0; i < 15; i++) send(5'd0, 1'b0, 1'b1, 1'b0);
    check("R9 exc field saturates", stat_word, 16'hF011);
    check("R3 irq from top field", {15'd0, irq}, 16'h0001);

    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 async reset", stat_word, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    @(negedge clk);
    finish_run();
  end

endmodule